// File: doc/BRIEF.md
# Command-Queue I2C Bus Master

This block is an I2C controller that needs no processor interaction once words are queued. Software pushes 10-bit command words into a small transmit queue. Each word holds one byte plus two control flags: one requests a bus start condition and one requests a stop condition. The engine turns each word into bus activity. It generates start and repeated-start conditions, shifts out address and data bytes, and checks the acknowledge bit. It also clocks in bytes on read cycles and places them into a receive queue.

A transaction opens with a start word. That word carries the 7-bit target address in bits 7:1 and the direction in bit 0. In write direction, every later word is a byte to send. In read direction, every later word is a placeholder: it asks for one byte from the target, and its low byte is ignored. While the bus is held, the engine keeps SCL low until the next word arrives. If the target fails to acknowledge, the engine halts until a word with the stop flag arrives. If SDA reads low while the engine has released it, the engine gives up the bus.

SCL timing comes from two programmable counts of system clocks, one for the high phase and one for the low phase. Both bus lines are open-drain: each output enable pulls its line low.

Top module: `i2c_cmd_master`

## Requirements
- R1: A command word holds the byte in bits 7:0, a start request in bit 8 and a stop request in bit 9. A word with bit 8 set is sent after a start condition, or after a repeated start if the bus is already held. Bit 0 of that byte (1 = read) sets the direction for the words that follow. While the bus is idle, words without bit 8 are discarded.
- R2: In write direction, each word's byte is shifted out MSB first, followed by one acknowledge clock. If the word has bit 9 set, a stop condition follows that acknowledge.
- R3: In read direction, each word clocks in one byte, MSB first, into the receive queue, and the word's bits 7:0 are ignored. The master acknowledges the byte by driving SDA low, unless the word has bit 9 set. In that case the master leaves SDA high (no acknowledge) and then issues a stop.
- R4: When an address or write byte is not acknowledged, `nack_flag` is set and the engine halts with SCL held low. Words without bit 9 are then discarded. The next word with bit 9 set produces a stop condition.
- R5: If SDA is sampled low during an address or write bit that the master left released, `arb_flag` is set, both lines are released and `bus_active` drops.
- R6: `bus_active` rises when a start condition begins and falls only after a stop condition has completed on the wire, or after arbitration loss.
- R7: During a data bit, SCL stays released for `scl_hi_cnt`+1 clocks and is driven low for `scl_lo_cnt`+1 clocks. The high-phase count does not advance while the SCL input reads low.
- R8: `need_data` is high exactly while the engine holds the bus between bytes with an empty transmit queue, and SCL is held low during that time.
- R9: `done_flag` is set when a stop condition completes. `done_flag`, `nack_flag` and `arb_flag` stay set until a `flag_clr` pulse.
- R10: Both queues are 4 entries deep and first-in first-out. A push into a full queue is dropped, so a fifth unread received byte is lost.
- R11: SDA changes only while SCL is low, except when forming start and stop conditions. Received bits are sampled at the midpoint of the SCL high phase.
- R12: After reset, both lines are released, all flags and `bus_active` are low, and the receive queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 10 | Command word to queue |
| cmd_push | input | 1 | Push `cmd_word` into the transmit queue |
| cmd_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the head byte of the receive queue |
| rx_byte | output | 8 | Head byte of the receive queue |
| rx_avail | output | 1 | Receive queue not empty |
| scl_hi_cnt | input | 10 | SCL high-phase length in clocks, minus one |
| scl_lo_cnt | input | 10 | SCL low-phase length in clocks, minus one |
| flag_clr | input | 1 | Clears the sticky flags |
| scl_i | input | 1 | SCL line as seen on the pad |
| sda_i | input | 1 | SDA line as seen on the pad |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| bus_active | output | 1 | Bus owned, from start to completed stop |
| need_data | output | 1 | Bus held, waiting for a command word |
| nack_flag | output | 1 | Sticky: address or write byte not acknowledged |
| arb_flag | output | 1 | Sticky: arbitration lost |
| done_flag | output | 1 | Sticky: stop condition completed |

## Verification
The bench builds the block with its default queue depth of 4 and 10-bit counters, and programs high and low counts of 6 and 8. Short counts keep each byte near 150 clocks, so write, read, repeated-start, halted and arbitration cases all fit in a short run. With a depth of 4, a five-byte read overflows the receive queue, so the dropped fifth byte can be observed at the ports. A small open-drain target model on the two lines scores written bytes against a queue of expected bytes. It also records the master's acknowledge choices on reads.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int WORD_W = 10;
  localparam int BYTE_W = 8;
  localparam int F_START = 8;
  localparam int F_STOP  = 9;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_BIT_LO, S_BIT_HI, S_HELD,
    S_RS_LO, S_RS_HI, S_SP_LO, S_SP_HI, S_SP_REL
  } eng_st_t;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_n, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (do_push) wp_n = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_n = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop) cnt_n = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  // R10: a push into a full queue leaves the occupancy unchanged
  a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt_q));
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  hi_cnt,
  input  logic [CNT_W-1:0]  lo_cnt,
  input  logic [WORD_W-1:0] word,
  input  logic              word_avail,
  output logic              word_pop,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_we,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              flag_clr,
  output logic              bus_active,
  output logic              need_data,
  output logic              nack_flag,
  output logic              arb_flag,
  output logic              done_flag
);
  localparam logic [3:0] ACK_BIT = 4'd8;

  eng_st_t           st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [3:0]        bit_q, bit_n;
  logic              rd_mode_q, rd_mode_n, byte_rd_q, byte_rd_n;
  logic              stop_q, stop_n, halt_q, halt_n, busy_q, busy_n;
  logic              scl_q, scl_n, sda_q, sda_n;
  logic              nack_q, nack_n, arb_q, arb_n, done_q, done_n;
  logic              tick_lo, tick_hi, mid, drive_bit, nack_now;

  assign tick_lo = (cnt_q == lo_cnt);
  assign tick_hi = (cnt_q == hi_cnt);
  assign mid     = (cnt_q == (hi_cnt >> 1));
  assign drive_bit = (bit_q < ACK_BIT) ? (!byte_rd_q && !sh_q[7])
                                       : (byte_rd_q && !stop_q);
  assign nack_now  = mid && (bit_q == ACK_BIT) && !byte_rd_q && sda_i;

  always_comb begin
    st_n = st_q;  cnt_n = cnt_q + 1'b1;  sh_n = sh_q;  bit_n = bit_q;
    rd_mode_n = rd_mode_q;  byte_rd_n = byte_rd_q;  stop_n = stop_q;
    halt_n = halt_q;  busy_n = busy_q;  scl_n = scl_q;  sda_n = sda_q;
    nack_n = nack_q && !flag_clr;
    arb_n  = arb_q && !flag_clr;
    done_n = done_q && !flag_clr;
    word_pop = 1'b0;
    rx_we    = 1'b0;
    case (st_q)
      S_IDLE: begin
        scl_n = 1'b0;  sda_n = 1'b0;  cnt_n = '0;
        if (word_avail) begin
          word_pop = 1'b1;
          if (word[F_START]) begin
            sh_n = word[7:0];  rd_mode_n = word[0];  byte_rd_n = 1'b0;
            stop_n = word[F_STOP];  halt_n = 1'b0;  busy_n = 1'b1;
            sda_n = 1'b1;  st_n = S_START;
          end
        end
      end
      S_START: if (tick_hi) begin
        cnt_n = '0;  scl_n = 1'b1;  bit_n = '0;  st_n = S_BIT_LO;
      end
      S_BIT_LO: begin
        if (cnt_q == '0) sda_n = drive_bit;
        if (tick_lo) begin
          cnt_n = '0;  scl_n = 1'b0;  st_n = S_BIT_HI;
        end
      end
      S_BIT_HI: begin
        if (!scl_i) cnt_n = cnt_q;
        else if (mid && bit_q < ACK_BIT && !byte_rd_q && !sda_q && !sda_i) begin
          arb_n = 1'b1;  busy_n = 1'b0;  scl_n = 1'b0;  sda_n = 1'b0;
          cnt_n = '0;  st_n = S_IDLE;
        end else begin
          if (mid && bit_q < ACK_BIT) sh_n = {sh_q[6:0], sda_i};
          if (mid && bit_q == ACK_BIT && byte_rd_q) rx_we = 1'b1;
          if (nack_now) begin
            nack_n = 1'b1;  halt_n = 1'b1;
          end
          if (tick_hi) begin
            cnt_n = '0;  scl_n = 1'b1;
            if (bit_q != ACK_BIT) begin
              bit_n = bit_q + 1'b1;  st_n = S_BIT_LO;
            end else if (halt_q || nack_now || !stop_q) st_n = S_HELD;
            else st_n = S_SP_LO;
          end
        end
      end
      S_HELD: begin
        cnt_n = '0;
        if (word_avail) begin
          word_pop = 1'b1;
          if (halt_q) begin
            if (word[F_STOP]) begin
              halt_n = 1'b0;  st_n = S_SP_LO;
            end
          end else if (word[F_START]) begin
            sh_n = word[7:0];  rd_mode_n = word[0];  byte_rd_n = 1'b0;
            stop_n = word[F_STOP];  st_n = S_RS_LO;
          end else begin
            sh_n = word[7:0];  byte_rd_n = rd_mode_q;  stop_n = word[F_STOP];
            bit_n = '0;  st_n = S_BIT_LO;
          end
        end
      end
      S_RS_LO: begin
        if (cnt_q == '0) sda_n = 1'b0;
        if (tick_lo) begin
          cnt_n = '0;  scl_n = 1'b0;  st_n = S_RS_HI;
        end
      end
      S_RS_HI: begin
        if (!scl_i) cnt_n = cnt_q;
        else if (tick_hi) begin
          cnt_n = '0;  sda_n = 1'b1;  st_n = S_START;
        end
      end
      S_SP_LO: begin
        if (cnt_q == '0) sda_n = 1'b1;
        if (tick_lo) begin
          cnt_n = '0;  scl_n = 1'b0;  st_n = S_SP_HI;
        end
      end
      S_SP_HI: begin
        if (!scl_i) cnt_n = cnt_q;
        else if (tick_hi) begin
          cnt_n = '0;  sda_n = 1'b0;  st_n = S_SP_REL;
        end
      end
      S_SP_REL: if (tick_hi) begin
        cnt_n = '0;  busy_n = 1'b0;  done_n = 1'b1;  st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  cnt_q <= '0;  sh_q <= '0;  bit_q <= '0;
      rd_mode_q <= 1'b0;  byte_rd_q <= 1'b0;  stop_q <= 1'b0;
      halt_q <= 1'b0;  busy_q <= 1'b0;  scl_q <= 1'b0;  sda_q <= 1'b0;
      nack_q <= 1'b0;  arb_q <= 1'b0;  done_q <= 1'b0;
    end else begin
      st_q <= st_n;  cnt_q <= cnt_n;  sh_q <= sh_n;  bit_q <= bit_n;
      rd_mode_q <= rd_mode_n;  byte_rd_q <= byte_rd_n;  stop_q <= stop_n;
      halt_q <= halt_n;  busy_q <= busy_n;  scl_q <= scl_n;  sda_q <= sda_n;
      nack_q <= nack_n;  arb_q <= arb_n;  done_q <= done_n;
    end
  end

  assign scl_oe     = scl_q;
  assign sda_oe     = sda_q;
  assign rx_data    = sh_q;
  assign bus_active = busy_q;
  assign need_data  = (st_q == S_HELD) && !word_avail;
  assign nack_flag  = nack_q;
  assign arb_flag   = arb_q;
  assign done_flag  = done_q;

  // R11: SDA drive holds steady across a whole bit high phase
  a_r11_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BIT_HI && $past(st_q) == S_BIT_HI) |-> $stable(sda_q));
  // R8: waiting for a word always keeps SCL pulled low
  a_r8_need_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    need_data |-> scl_oe);
  // R6: losing the bus leaves both lines released
  a_r6_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (!scl_q && !sda_q));
  // R4: a halted engine keeps the clock line low
  a_r4_halt_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && st_q == S_HELD) |-> scl_q);
  // R5: arbitration loss releases both lines in the same cycle
  a_r5_arb_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_q) |-> (!scl_q && !sda_q && !busy_q));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2cm_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int TX_DEPTH   = 4,
  parameter int RX_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              cmd_push,
  output logic              cmd_full,
  input  logic              rx_pop,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_avail,
  input  logic [CNT_W-1:0]  scl_hi_cnt,
  input  logic [CNT_W-1:0]  scl_lo_cnt,
  input  logic              flag_clr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              bus_active,
  output logic              need_data,
  output logic              nack_flag,
  output logic              arb_flag,
  output logic              done_flag
);
  logic [WORD_W-1:0] tx_head;
  logic [BYTE_W-1:0] eng_rx;
  logic              tx_empty, tx_pop, rx_we, rx_full, rx_empty;

  i2cm_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(cmd_word), .full(cmd_full),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty));

  i2cm_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_we), .din(eng_rx), .full(rx_full),
    .pop(rx_pop), .dout(rx_byte), .empty(rx_empty));

  i2cm_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .hi_cnt(scl_hi_cnt), .lo_cnt(scl_lo_cnt),
    .word(tx_head), .word_avail(!tx_empty), .word_pop(tx_pop),
    .rx_data(eng_rx), .rx_we(rx_we), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .flag_clr(flag_clr),
    .bus_active(bus_active), .need_data(need_data), .nack_flag(nack_flag),
    .arb_flag(arb_flag), .done_flag(done_flag));

  assign rx_avail = !rx_empty;

  // R10: a received byte arriving at a full queue is not stored
  a_r10_rx_drop_kept_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_we && rx_full && !rx_pop) |=> !rx_empty);
endmodule

// File: tb/i2c_cmd_master_bench.sv
`timescale 1ns/1ps
module i2c_cmd_master_bench;
  localparam int HI = 6;
  localparam int LO = 8;
  localparam logic [6:0] TGT = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] cmd_word = '0;
  logic cmd_push = 1'b0, rx_pop = 1'b0, flag_clr = 1'b0;
  logic cmd_full, rx_avail, scl_oe, sda_oe, bus_active, need_data;
  logic nack_flag, arb_flag, done_flag;
  logic [7:0] rx_byte;
  logic slv_low = 1'b0, arb_force = 1'b0, mon_en = 1'b1;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || slv_low || arb_force);

  int tests = 0, fails = 0;
  int sl_bits = 0, sl_phase = 3, sl_idx = 0, sl_starts = 0, sl_stops = 0;
  int sl_macks = 0, sl_mnacks = 0;
  logic [7:0] sl_sh = '0;
  logic sl_rw = 1'b0, sl_lastn = 1'b0;
  logic [7:0] wr_q[$];
  logic [7:0] rd_q[$];
  realtime t_rise, t_fall, t_rise2;

  always #2 clk = !clk;

  i2c_cmd_master u_i2c_cmd_master (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_push(cmd_push),
    .cmd_full(cmd_full), .rx_pop(rx_pop), .rx_byte(rx_byte), .rx_avail(rx_avail),
    .scl_hi_cnt(10'(HI)), .scl_lo_cnt(10'(LO)), .flag_clr(flag_clr),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .bus_active(bus_active), .need_data(need_data), .nack_flag(nack_flag),
    .arb_flag(arb_flag), .done_flag(done_flag));

  function automatic logic [7:0] rbyte(input int i);
    return 8'h96 + 8'(i * 27);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // target model on the open-drain lines
  always @(negedge sda_w) if (scl_w === 1'b1) begin
    sl_starts++; sl_bits = 0; sl_phase = 0; sl_idx = 0; slv_low = 1'b0;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    sl_stops++; sl_phase = 3; slv_low = 1'b0;
  end
  always @(posedge scl_w) if (sl_phase != 3) begin
    if (sl_bits < 8) sl_sh = {sl_sh[6:0], sda_w};
    else if (sl_phase == 2) begin
      sl_lastn = sda_w;
      if (sda_w) sl_mnacks++; else sl_macks++;
    end
    sl_bits++;
  end
  always @(negedge scl_w) if (sl_phase != 3) begin
    if (sl_bits == 8) begin
      if (sl_phase == 0) begin
        if (sl_sh[7:1] == TGT) begin slv_low = 1'b1; sl_rw = sl_sh[0]; end
        else sl_phase = 3;
      end else if (sl_phase == 1) begin
        // scoreboard monitor for written bytes (R2)
        if (wr_q.size() == 0) chk("R2 unexpected byte", sl_sh, 0);
        else chk("R2 written byte", sl_sh, wr_q.pop_front());
        slv_low = 1'b1;
      end else slv_low = 1'b0;
    end else if (sl_bits == 9) begin
      sl_bits = 0;
      if (sl_phase == 0) sl_phase = sl_rw ? 2 : 1;
      else if (sl_phase == 2) begin
        sl_idx++;
        if (sl_lastn) sl_phase = 3;
      end
      slv_low = (sl_phase == 2) ? !rbyte(sl_idx)[7] : 1'b0;
    end else if (sl_phase == 2 && sl_bits > 0 && sl_bits < 8) begin
      slv_low = !rbyte(sl_idx)[7 - sl_bits];
    end
  end

  // scoreboard monitor for received bytes (R3)
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && rx_avail) begin
        if (rd_q.size() == 0) chk("R3 unexpected rx byte", rx_byte, 0);
        else chk("R3 received byte", rx_byte, rd_q.pop_front());
        rx_pop = 1'b1;
      end else rx_pop = 1'b0;
    end
  end

  task automatic push_word(input logic [9:0] w);
    @(negedge clk);
    while (cmd_full) @(negedge clk);
    cmd_word = w; cmd_push = 1'b1;
    @(negedge clk);
    cmd_push = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (20) @(negedge clk);
    while (bus_active) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic zero_counts();
    sl_starts = 0; sl_stops = 0; sl_macks = 0; sl_mnacks = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R12 reset state
    chk("R12 scl_oe", scl_oe, 0);
    chk("R12 sda_oe", sda_oe, 0);
    chk("R12 bus_active", bus_active, 0);
    chk("R12 rx_avail", rx_avail, 0);
    chk("R12 flags", {nack_flag, arb_flag, done_flag}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    zero_counts();

    // R1 R2 R7 R9: write with stop on last byte
    fork
      begin
        @(posedge scl_w); t_rise = $realtime;
        @(negedge scl_w); t_fall = $realtime;
        @(posedge scl_w); t_rise2 = $realtime;
      end
    join_none
    wr_q.push_back(8'hA5); wr_q.push_back(8'h3C);
    push_word(10'h100 | {TGT, 1'b0});
    push_word(10'h0A5);
    push_word(10'h23C);
    repeat (30) @(negedge clk);
    chk("R6 bus_active during transfer", bus_active, 1);
    wait_idle();
    chk("R2 all bytes seen", wr_q.size(), 0);
    chk("R2 one stop", sl_stops, 1);
    chk("R9 done set", done_flag, 1);
    chk("R7 high clocks", int'((t_fall - t_rise) / 4.0), HI + 1);
    chk("R7 low clocks", int'((t_rise2 - t_fall) / 4.0), LO + 1);
    pulse_clr();
    chk("R9 done cleared", done_flag, 0);

    // R3: read three bytes, low byte of the placeholder ignored
    zero_counts();
    for (int i = 0; i < 3; i++) rd_q.push_back(rbyte(i));
    push_word(10'h100 | {TGT, 1'b1});
    push_word(10'h0FF);
    push_word(10'h000);
    push_word(10'h2AA);
    wait_idle();
    chk("R3 rx bytes drained", rd_q.size(), 0);
    chk("R3 master acks", sl_macks, 2);
    chk("R3 final nack", sl_mnacks, 1);
    chk("R3 stop after nack", sl_stops, 1);
    pulse_clr();

    // R1: repeated start switching to read
    zero_counts();
    wr_q.push_back(8'h5A);
    rd_q.push_back(rbyte(0));
    push_word(10'h100 | {TGT, 1'b0});
    push_word(10'h05A);
    push_word(10'h100 | {TGT, 1'b1});
    push_word(10'h200);
    wait_idle();
    chk("R1 two starts", sl_starts, 2);
    chk("R1 one stop", sl_stops, 1);
    chk("R1 rx after restart", rd_q.size(), 0);
    pulse_clr();

    // R8: bus held waiting for data
    wr_q.push_back(8'h77);
    push_word(10'h100 | {TGT, 1'b0});
    for (int i = 0; i < 600 && !need_data; i++) @(negedge clk);
    chk("R8 need_data", need_data, 1);
    chk("R8 scl held low", scl_oe, 1);
    chk("R8 bus held", bus_active, 1);
    push_word(10'h277);
    wait_idle();
    chk("R8 need_data cleared", need_data, 0);
    chk("R8 byte delivered", wr_q.size(), 0);
    pulse_clr();

    // R4: unacknowledged address
    zero_counts();
    push_word(10'h100 | {7'h33, 1'b0});
    for (int i = 0; i < 600 && !nack_flag; i++) @(negedge clk);
    chk("R4 nack flag", nack_flag, 1);
    push_word(10'h044);
    repeat (100) @(negedge clk);
    chk("R4 data word ignored, bus held", bus_active, 1);
    chk("R4 scl low while halted", scl_oe, 1);
    chk("R4 no stop yet", sl_stops, 0);
    push_word(10'h2FF);
    wait_idle();
    chk("R4 stop issued", sl_stops, 1);
    chk("R4 done after stop", done_flag, 1);
    pulse_clr();
    chk("R9 nack cleared", nack_flag, 0);

    // R5: arbitration loss on a released address bit
    push_word(10'h100 | {TGT, 1'b0});
    @(negedge scl_w);
    arb_force = 1'b1;
    for (int i = 0; i < 200 && !arb_flag; i++) @(negedge clk);
    arb_force = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 arb flag", arb_flag, 1);
    chk("R5 bus dropped", bus_active, 0);
    chk("R5 lines released", {scl_oe, sda_oe}, 0);
    pulse_clr();
    repeat (20) @(negedge clk);

    // R10: five-byte read with no popping; fifth byte lost
    mon_en = 1'b0;
    push_word(10'h100 | {TGT, 1'b1});
    for (int i = 0; i < 4; i++) push_word(10'h000);
    push_word(10'h200);
    wait_idle();
    for (int i = 0; i < 4; i++) rd_q.push_back(rbyte(i));
    mon_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 four bytes kept in order", rd_q.size(), 0);
    chk("R10 fifth byte dropped", rx_avail, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule